// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block settles conditional branches while the branch instruction is still in the decode stage of a five-stage pipeline, rather than waiting for a later stage. It receives the two operands read from the register file, the incremented PC that travelled with the instruction, and the raw 16-bit offset field. It widens the offset to the full data width and forms the target address. An equality comparator then decides whether a branch-if-equal or branch-if-not-equal is taken.

The block drives the next-fetch address and a cancel request for the instruction now being fetched. It also holds the control bits of the fetch/decode pipeline register. When a branch is taken and the build has no delay slot, those bits are cleared to zero on the next clock edge, which turns the wrong-path instruction into a no-op. When a delay slot is configured, the instruction after the branch always proceeds and nothing is cancelled. Operand forwarding into the comparator and any prediction are left to surrounding logic.

Top module: `decode_branch_resolver`

## Requirements
- R1: `branch_target` always equals `link_pc` plus the offset, where the offset is `imm16` sign-extended to XLEN bits and shifted left by two.
- R2: When `dec_valid` is high and `dec_kind` is 2'b01 (branch if equal), `taken` is high exactly when `rs_val` equals `rt_val`.
- R3: When `dec_valid` is high and `dec_kind` is 2'b10 (branch if not equal), `taken` is high exactly when `rs_val` differs from `rt_val`.
- R4: `next_pc` equals `branch_target` while `taken` is high, and equals `seq_pc` otherwise.
- R5: When `dec_valid` is low, or `dec_kind` is 2'b00 (not a branch) or 2'b11 (reserved), `taken` and `flush_fetch` are both low.
- R6: With DELAY_SLOT=0, `flush_fetch` follows `taken`, and after a cycle with `flush_fetch` high, `ifid_ctrl` is all zeros following the next rising edge.
- R7: In any cycle where `flush_fetch` is low, `ifid_ctrl` takes the value of `fetch_ctrl` at the next rising edge.
- R8: With DELAY_SLOT=1, `flush_fetch` is never high, so the instruction right after a taken branch keeps its control bits.
- R9: While `rst_n` is low, `ifid_ctrl` is all zeros.
- R10: A negative offset (bit 15 of `imm16` set) produces a target below `link_pc`, with every upper bit of the offset set to one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_valid | input | 1 | Decode stage holds a real instruction |
| dec_kind | input | 2 | 00 none, 01 branch-if-equal, 10 branch-if-not-equal, 11 reserved |
| rs_val | input | XLEN | First register-file read value |
| rt_val | input | XLEN | Second register-file read value |
| link_pc | input | XLEN | Incremented PC of the decoding instruction |
| imm16 | input | IMM_W | Raw offset field |
| seq_pc | input | XLEN | Sequential next-fetch address |
| fetch_ctrl | input | CTRL_W | Control bits of the instruction being fetched |
| branch_target | output | XLEN | Computed branch destination |
| taken | output | 1 | Branch resolved as taken |
| next_pc | output | XLEN | Selected next-fetch address |
| flush_fetch | output | 1 | Cancel the instruction now being fetched |
| ifid_ctrl | output | CTRL_W | Control bits held in the fetch/decode register |

## Verification
The hardest case to reach is the interplay between a taken branch and the next edge: the fetch-side control bits are non-zero and must disappear in one build but survive in the delay-slot build. For this, two instances with opposite DELAY_SLOT settings share the same stimulus. Every vector drives a distinctive non-zero `fetch_ctrl`, and the register is sampled one edge later. Equal and unequal operand pairs that differ only in the top or bottom bit, together with offsets of 0x7FFF and 0x8000, check the comparator width and the sign extension.

// File: rtl/bres_pkg.sv
package bres_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'b00,
    KIND_EQ   = 2'b01,
    KIND_NE   = 2'b10,
    KIND_RSVD = 2'b11
  } br_kind_e;

  function automatic logic [31:0] widen_offset(input logic [15:0] raw);
    widen_offset = {{14{raw[15]}}, raw, 2'b00};
  endfunction

  function automatic logic is_branch(input logic [1:0] k);
    is_branch = (k == KIND_EQ) || (k == KIND_NE);
  endfunction
endpackage

// File: rtl/bres_target_adder.sv
module bres_target_adder #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [XLEN-1:0]  base,
  input  logic [IMM_W-1:0] raw_off,
  output logic [XLEN-1:0]  target
);
  localparam int PAD = XLEN - IMM_W - 2;
  logic [XLEN-1:0] scaled;
  always_comb begin
    scaled = {{PAD{raw_off[IMM_W-1]}}, raw_off, 2'b00};
    target = base + scaled;
  end
endmodule

// File: rtl/bres_eq_cmp.sv
module bres_eq_cmp #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            same
);
  logic [XLEN-1:0] diff;
  always_comb begin
    diff = a ^ b;
    same = (diff == '0);
  end
endmodule

// File: rtl/bres_slot_reg.sv
module bres_slot_reg #(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kill,
  input  logic [CTRL_W-1:0] d,
  output logic [CTRL_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (kill) q <= '0;
    else           q <= d;
  end
endmodule

// File: rtl/decode_branch_resolver.sv
module decode_branch_resolver #(
  parameter int XLEN       = 32,
  parameter int IMM_W      = 16,
  parameter int CTRL_W     = 8,
  parameter bit DELAY_SLOT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  input  logic [1:0]        dec_kind,
  input  logic [XLEN-1:0]   rs_val,
  input  logic [XLEN-1:0]   rt_val,
  input  logic [XLEN-1:0]   link_pc,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [XLEN-1:0]   seq_pc,
  input  logic [CTRL_W-1:0] fetch_ctrl,
  output logic [XLEN-1:0]   branch_target,
  output logic              taken,
  output logic [XLEN-1:0]   next_pc,
  output logic              flush_fetch,
  output logic [CTRL_W-1:0] ifid_ctrl
);
  import bres_pkg::*;

  logic ops_equal;
  logic want_eq;
  logic want_ne;

  bres_target_adder #(.XLEN(XLEN), .IMM_W(IMM_W)) u_adder (
    .base(link_pc), .raw_off(imm16), .target(branch_target)
  );

  bres_eq_cmp #(.XLEN(XLEN)) u_cmp (
    .a(rs_val), .b(rt_val), .same(ops_equal)
  );

  always_comb begin
    want_eq = dec_valid && (dec_kind == KIND_EQ);
    want_ne = dec_valid && (dec_kind == KIND_NE);
    taken   = (want_eq && ops_equal) || (want_ne && !ops_equal);
    next_pc = taken ? branch_target : seq_pc;
  end

  generate
    if (DELAY_SLOT) begin : g_slot
      assign flush_fetch = 1'b0;
    end else begin : g_noslot
      assign flush_fetch = taken;
    end
  endgenerate

  bres_slot_reg #(.CTRL_W(CTRL_W)) u_ifid (
    .clk(clk), .rst_n(rst_n), .kill(flush_fetch), .d(fetch_ctrl), .q(ifid_ctrl)
  );
endmodule

// File: rtl/decode_branch_resolver_chk.sv
module decode_branch_resolver_chk #(
  parameter int XLEN       = 32,
  parameter int CTRL_W     = 8,
  parameter bit DELAY_SLOT = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dec_valid,
  input logic [1:0]        dec_kind,
  input logic [XLEN-1:0]   rs_val,
  input logic [XLEN-1:0]   rt_val,
  input logic [XLEN-1:0]   seq_pc,
  input logic [CTRL_W-1:0] fetch_ctrl,
  input logic [XLEN-1:0]   branch_target,
  input logic              taken,
  input logic [XLEN-1:0]   next_pc,
  input logic              flush_fetch,
  input logic [CTRL_W-1:0] ifid_ctrl
);
  assert_eq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_kind == 2'b01) |-> (taken == (rs_val == rt_val)));
  assert_ne_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_kind == 2'b10) |-> (taken == (rs_val != rt_val)));
  assert_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    next_pc == (taken ? branch_target : seq_pc));
  assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_valid || dec_kind == 2'b00 || dec_kind == 2'b11) |-> (!taken && !flush_fetch));
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_fetch |=> (ifid_ctrl == '0));
  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_fetch |=> (ifid_ctrl == $past(fetch_ctrl)));
  assert_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    DELAY_SLOT |-> !flush_fetch);
  assert_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !DELAY_SLOT |-> (flush_fetch == taken));
endmodule

bind decode_branch_resolver decode_branch_resolver_chk #(
  .XLEN(XLEN), .CTRL_W(CTRL_W), .DELAY_SLOT(DELAY_SLOT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_kind(dec_kind),
  .rs_val(rs_val), .rt_val(rt_val), .seq_pc(seq_pc), .fetch_ctrl(fetch_ctrl),
  .branch_target(branch_target), .taken(taken), .next_pc(next_pc),
  .flush_fetch(flush_fetch), .ifid_ctrl(ifid_ctrl)
);

// File: tb/decode_branch_resolver_test.sv
`timescale 1ns/1ps
module decode_branch_resolver_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_valid = 1'b0;
  logic [1:0]  dec_kind = 2'b00;
  logic [31:0] rs_val = '0, rt_val = '0, link_pc = '0, seq_pc = '0;
  logic [15:0] imm16 = '0;
  logic [7:0]  fetch_ctrl = '0;

  logic [31:0] tgt_a, npc_a, tgt_b, npc_b;
  logic        tk_a, fl_a, tk_b, fl_b;
  logic [7:0]  ctl_a, ctl_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  decode_branch_resolver #(.DELAY_SLOT(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_kind(dec_kind),
    .rs_val(rs_val), .rt_val(rt_val), .link_pc(link_pc), .imm16(imm16),
    .seq_pc(seq_pc), .fetch_ctrl(fetch_ctrl), .branch_target(tgt_a),
    .taken(tk_a), .next_pc(npc_a), .flush_fetch(fl_a), .ifid_ctrl(ctl_a));

  decode_branch_resolver #(.DELAY_SLOT(1'b1)) uut_ds (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_kind(dec_kind),
    .rs_val(rs_val), .rt_val(rt_val), .link_pc(link_pc), .imm16(imm16),
    .seq_pc(seq_pc), .fetch_ctrl(fetch_ctrl), .branch_target(tgt_b),
    .taken(tk_b), .next_pc(npc_b), .flush_fetch(fl_b), .ifid_ctrl(ctl_b));

  typedef struct {
    string       tag;
    logic [31:0] tgt;
    logic        tk;
    logic [31:0] npc;
    logic [7:0]  ctl_a;
    logic [7:0]  ctl_b;
  } exp_t;
  exp_t sb[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input string tag, input logic v, input logic [1:0] k,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] lpc, input logic [15:0] im,
                       input logic [31:0] spc, input logic [7:0] fc);
    exp_t e;
    logic [31:0] off;
    logic br;
    @(negedge clk);
    dec_valid = v; dec_kind = k; rs_val = a; rt_val = b;
    link_pc = lpc; imm16 = im; seq_pc = spc; fetch_ctrl = fc;
    off = im[15] ? (32'hFFFC0000 | (32'(im) << 2)) : (32'(im) << 2);
    br = 1'b0;
    if (v && k == 2'b01 && a == b) br = 1'b1;
    if (v && k == 2'b10 && a != b) br = 1'b1;
    e.tag = tag;
    e.tgt = lpc + off;
    e.tk  = br;
    e.npc = br ? lpc + off : spc;
    e.ctl_a = br ? 8'h00 : fc;
    e.ctl_b = fc;
    #1;
    sb.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      wait (sb.size() > 0);
      e = sb.pop_front();
      check({e.tag, " R1 target"}, tgt_a, e.tgt);
      check({e.tag, " R2/R3 taken"}, 32'(tk_a), 32'(e.tk));
      check({e.tag, " R4 next_pc"}, npc_a, e.npc);
      check({e.tag, " R6 flush"}, 32'(fl_a), 32'(e.tk));
      check({e.tag, " R8 ds flush"}, 32'(fl_b), 32'h0);
      check({e.tag, " R4 ds next_pc"}, npc_b, e.npc);
      @(posedge clk); #1;
      check({e.tag, " R6/R7 ifid"}, 32'(ctl_a), 32'(e.ctl_a));
      check({e.tag, " R8 ds ifid"}, 32'(ctl_b), 32'(e.ctl_b));
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    fetch_ctrl = 8'hA5;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset ifid", 32'(ctl_a), 32'h0);
    check("R9 reset ds ifid", 32'(ctl_b), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    // R2 equal operands, taken
    drive("R2 eq-hit", 1, 2'b01, 32'h1234_5678, 32'h1234_5678, 32'h0000_1000, 16'h0010, 32'h0000_2004, 8'h3C);
    // R2 differ in LSB only, not taken
    drive("R2 eq-miss-lsb", 1, 2'b01, 32'h0000_0001, 32'h0000_0000, 32'h0000_1000, 16'h0010, 32'h0000_2008, 8'h5A);
    // R2 differ in MSB only
    drive("R2 eq-miss-msb", 1, 2'b01, 32'h8000_0000, 32'h0000_0000, 32'h0000_1000, 16'h0004, 32'h0000_200C, 8'h11);
    // R3 not-equal taken
    drive("R3 ne-hit", 1, 2'b10, 32'hDEAD_BEEF, 32'hDEAD_BEEE, 32'h0040_0000, 16'h7FFF, 32'h0000_3000, 8'hC3);
    // R3 not-equal with equal operands
    drive("R3 ne-miss", 1, 2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0040_0000, 16'h0001, 32'h0000_3004, 8'h77);
    // R10 negative offsets
    drive("R10 back-min", 1, 2'b01, 32'h0, 32'h0, 32'h0001_0000, 16'h8000, 32'h0000_4000, 8'h99);
    drive("R10 back-one", 1, 2'b10, 32'h5, 32'h6, 32'h0000_0100, 16'hFFFF, 32'h0000_4004, 8'hE1);
    // R5 non-branch kinds and invalid decode
    drive("R5 none", 1, 2'b00, 32'h7, 32'h7, 32'h0000_0200, 16'h0008, 32'h0000_5000, 8'h42);
    drive("R5 reserved", 1, 2'b11, 32'h7, 32'h7, 32'h0000_0200, 16'h0008, 32'h0000_5004, 8'h24);
    drive("R5 invalid", 0, 2'b01, 32'h7, 32'h7, 32'h0000_0200, 16'h0008, 32'h0000_5008, 8'hFF);
    // R6 back-to-back taken, then R7 recovery
    drive("R6 taken-1", 1, 2'b01, 32'h9, 32'h9, 32'h0000_0800, 16'h0020, 32'h0000_6000, 8'h81);
    drive("R6 taken-2", 1, 2'b10, 32'h9, 32'hA, 32'h0000_0880, 16'hFFF0, 32'h0000_6004, 8'h18);
    drive("R7 after", 1, 2'b00, 32'h0, 32'h1, 32'h0000_0900, 16'h0000, 32'h0000_6008, 8'h66);
    for (int i = 0; i < 8; i++) begin
      logic [31:0] a;
      a = 32'h0101_0101 * (i + 1);
      drive("R2/R3 sweep", 1, (i % 2 == 0) ? 2'b01 : 2'b10, a, (i % 3 == 0) ? a : ~a,
            32'h0000_A000 + 32'(i * 4), 16'(i * 16'h1111), 32'h0000_B000 + 32'(i * 4), 8'(8'h10 + i));
    end
    wait (sb.size() == 0);
    @(posedge clk); #2;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule